// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal sync, vertical sync, blanking and active-window signals for a raster display, together with the byte address at which scan-out of the visible image begins. A horizontal counter advances one step per clock, and each step stands for a pair of pixels. A vertical counter advances by two at every line end, so vertical positions are held in half-line units. Ten programmable comparison points, set against these counters, place the sync pulses and the blanking edges.

Software loads all values through a plain write port. Each write carries a slot number and a data word, and every write is accepted. Sixteen slots hold timing values. Further slots hold the line pitch, the two pan offsets, the colour-depth code and a control word. The control word can force blanking, and it can switch off either sync, which gives the standby, suspend and off power states. Timing writes are held in a shadow copy and take effect only at a frame boundary. Pan, pitch and depth writes change the start address straight away and leave the raster undisturbed.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset, hsync and vsync are 0, blank is 1, active is 0 and start_addr is 0. The control word resets to forced blank with both syncs disabled.
- R2: A line lasts h_total+2 clocks, with h_total in slot 8. The horizontal position runs from 0 to h_total+1. hsync is high while the position is at or above h_sync_beg (slot 12) or below h_sync_end (slot 11).
- R3: A frame lasts v_total/2 lines, with v_total in slot 6. The vertical position steps by 2 at each line end and returns to 0 after the step at which position+2 >= v_total. vsync is high while the position is at or above v_sync_beg (slot 5) or below v_sync_end (slot 4).
- R4: active is high when h_blank_end (slot 10) <= h position < h_blank_beg (slot 9) and v_blank_end (slot 2) <= v position < v_blank_beg (slot 1). blank is the inverse of active unless blanking is forced. All four raster outputs are registered one clock after the counters.
- R5: Control bit 10, written through slot 20, forces blank high. active keeps following the window.
- R6: Control bits 5:4 enable hsync and bits 1:0 enable vsync, where either bit of a pair is enough. With both bits of a pair clear, that sync stays low. This gives the vsync-suspend (0x030), hsync-suspend (0x003) and power-down (0x400) states.
- R7: start_addr = yoff*pitch + roundup32(xoff << depth), where pitch comes from slot 16 with bits 4:0 ignored, xoff from slot 17, yoff from slot 18 and depth from slot 19. Depth code 0 means 1 byte per pixel, code 1 means 2 bytes, and codes 2 and 3 mean 4 bytes. start_addr is always a multiple of 32.
- R8: Writes to the pitch, pan or depth slots update start_addr on the second rising edge after the write is presented. They do not change sync, blank or active timing.
- R9: Timing slot writes go to a shadow copy, which is loaded into the working copy at the next frame wrap. A line already under way keeps its old timing.
- R10: Slots 0, 3, 7, 13, 14 and 15 accept writes but change no output. Slots 21 to 31 are ignored in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one pixel pair per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, always accepted |
| wr_slot | input | 5 | Register slot number |
| wr_data | input | DW | Write data |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| blank | output | 1 | Blanking, high outside the window or when forced |
| active | output | 1 | Inside the visible window |
| start_addr | output | OW+DW | Scan-out start byte address |

## Verification
The raster outputs trail the counters by one register, so the bench avoids exact edge positions. It measures pulse widths and periods between sampled edges. It also counts high cycles over windows that are whole multiples of the frame length, and such counts do not depend on the starting phase. start_addr is sampled after the second rising edge following a write. Timing changes are checked twice: within the line after a mid-frame write, where the old period must still hold, and after the next vsync falling edge, where the new period must apply. Control-word effects are measured only after a settling gap of a few cycles.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int TW = 12;

  typedef struct packed {
    logic [TW-1:0] h_total;
    logic [TW-1:0] h_blank_beg;
    logic [TW-1:0] h_blank_end;
    logic [TW-1:0] h_sync_beg;
    logic [TW-1:0] h_sync_end;
    logic [TW-1:0] v_total;
    logic [TW-1:0] v_blank_beg;
    logic [TW-1:0] v_blank_end;
    logic [TW-1:0] v_sync_beg;
    logic [TW-1:0] v_sync_end;
  } timing_t;

  typedef struct packed {
    logic       force_blank;
    logic [1:0] hs_en;
    logic [1:0] vs_en;
  } ctrl_t;

  typedef enum logic [4:0] {
    SL_VWIN_BEG    = 5'd0,
    SL_VBLANK_BEG  = 5'd1,
    SL_VBLANK_END  = 5'd2,
    SL_VWIN_END    = 5'd3,
    SL_VSYNC_END   = 5'd4,
    SL_VSYNC_BEG   = 5'd5,
    SL_VTOTAL      = 5'd6,
    SL_FETCH_LEAD  = 5'd7,
    SL_HTOTAL      = 5'd8,
    SL_HBLANK_BEG  = 5'd9,
    SL_HBLANK_END  = 5'd10,
    SL_HSYNC_END   = 5'd11,
    SL_HSYNC_BEG   = 5'd12,
    SL_HEQ_PULSE   = 5'd13,
    SL_HHALF       = 5'd14,
    SL_HSER_PULSE  = 5'd15,
    SL_PITCH       = 5'd16,
    SL_XOFF        = 5'd17,
    SL_YOFF        = 5'd18,
    SL_DEPTH       = 5'd19,
    SL_CTRL        = 5'd20
  } slot_e;

  localparam int CTL_FORCE_BIT = 10;
  localparam int CTL_HS_LSB    = 4;
  localparam int CTL_VS_LSB    = 0;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int DW = 16,
  parameter int OW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [4:0]    wr_slot,
  input  logic [DW-1:0] wr_data,
  input  logic          frame_wrap,
  output timing_t       tm_o,
  output ctrl_t         ctrl_o,
  output logic [DW-6:0] pitch_hi_o,
  output logic [OW-1:0] xoff_o,
  output logic [OW-1:0] yoff_o,
  output logic [1:0]    depth_o
);
  timing_t shadow_q;
  timing_t work_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q   <= '0;
      work_q     <= '0;
      ctrl_o     <= '{force_blank: 1'b1, hs_en: 2'b00, vs_en: 2'b00};
      pitch_hi_o <= '0;
      xoff_o     <= '0;
      yoff_o     <= '0;
      depth_o    <= '0;
    end else begin
      if (wr_en) begin
        case (wr_slot)
          SL_HTOTAL:     shadow_q.h_total     <= wr_data[TW-1:0];
          SL_HBLANK_BEG: shadow_q.h_blank_beg <= wr_data[TW-1:0];
          SL_HBLANK_END: shadow_q.h_blank_end <= wr_data[TW-1:0];
          SL_HSYNC_BEG:  shadow_q.h_sync_beg  <= wr_data[TW-1:0];
          SL_HSYNC_END:  shadow_q.h_sync_end  <= wr_data[TW-1:0];
          SL_VTOTAL:     shadow_q.v_total     <= wr_data[TW-1:0];
          SL_VBLANK_BEG: shadow_q.v_blank_beg <= wr_data[TW-1:0];
          SL_VBLANK_END: shadow_q.v_blank_end <= wr_data[TW-1:0];
          SL_VSYNC_BEG:  shadow_q.v_sync_beg  <= wr_data[TW-1:0];
          SL_VSYNC_END:  shadow_q.v_sync_end  <= wr_data[TW-1:0];
          SL_PITCH:      pitch_hi_o <= wr_data[DW-1:5];
          SL_XOFF:       xoff_o     <= wr_data[OW-1:0];
          SL_YOFF:       yoff_o     <= wr_data[OW-1:0];
          SL_DEPTH:      depth_o    <= wr_data[1:0];
          SL_CTRL: begin
            ctrl_o.force_blank <= wr_data[CTL_FORCE_BIT];
            ctrl_o.hs_en       <= wr_data[CTL_HS_LSB+1:CTL_HS_LSB];
            ctrl_o.vs_en       <= wr_data[CTL_VS_LSB+1:CTL_VS_LSB];
          end
          default: ;
        endcase
      end
      if (frame_wrap) work_q <= shadow_q;
    end
  end

  assign tm_o = work_q;

  // R9
  work_copy_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_wrap |=> $stable(work_q));
endmodule

// File: rtl/rtg_counters.sv
module rtg_counters
  import rtg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] h_total,
  input  logic [TW-1:0] v_total,
  output logic [TW-1:0] hpos_o,
  output logic [TW-1:0] vpos_o,
  output logic          line_end_o,
  output logic          frame_wrap_o
);
  logic [TW:0] h_limit;
  logic        v_last;

  assign h_limit      = {1'b0, h_total} + (TW+1)'(1);
  assign line_end_o   = {1'b0, hpos_o} >= h_limit;
  assign v_last       = ({1'b0, vpos_o} + (TW+1)'(2)) >= {1'b0, v_total};
  assign frame_wrap_o = line_end_o & v_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hpos_o <= '0;
      vpos_o <= '0;
    end else if (line_end_o) begin
      hpos_o <= '0;
      vpos_o <= v_last ? '0 : vpos_o + TW'(2);
    end else begin
      hpos_o <= hpos_o + TW'(1);
    end
  end

  // R2
  hpos_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, hpos_o} <= h_limit);
  // R3
  vpos_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vpos_o[0] == 1'b0);
  // R3
  vpos_steps_at_line_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end_o |=> $stable(vpos_o));
endmodule

// File: rtl/rtg_window.sv
module rtg_window
  import rtg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  timing_t       tm,
  input  ctrl_t         ctrl,
  input  logic [TW-1:0] hpos,
  input  logic [TW-1:0] vpos,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          blank_o,
  output logic          active_o
);
  logic h_zone, v_zone, h_vis, v_vis, in_win;

  always_comb begin
    h_zone = (hpos >= tm.h_sync_beg) || (hpos < tm.h_sync_end);
    v_zone = (vpos >= tm.v_sync_beg) || (vpos < tm.v_sync_end);
    h_vis  = (hpos >= tm.h_blank_end) && (hpos < tm.h_blank_beg);
    v_vis  = (vpos >= tm.v_blank_end) && (vpos < tm.v_blank_beg);
    in_win = h_vis & v_vis;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsync_o  <= 1'b0;
      vsync_o  <= 1'b0;
      blank_o  <= 1'b1;
      active_o <= 1'b0;
    end else begin
      hsync_o  <= h_zone & (|ctrl.hs_en);
      vsync_o  <= v_zone & (|ctrl.vs_en);
      blank_o  <= ctrl.force_blank | ~in_win;
      active_o <= in_win;
    end
  end

  // R4
  unblank_only_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_o |-> active_o);
  // R5
  forced_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.force_blank |=> blank_o);
  // R6
  hsync_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.hs_en == 2'b00) |=> !hsync_o);
  // R6
  vsync_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.vs_en == 2'b00) |=> !vsync_o);
endmodule

// File: rtl/rtg_addr.sv
module rtg_addr #(
  parameter int DW = 16,
  parameter int OW = 12,
  parameter int AW = OW + DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-6:0] pitch_hi,
  input  logic [OW-1:0] xoff,
  input  logic [OW-1:0] yoff,
  input  logic [1:0]    depth,
  output logic [AW-1:0] start_addr_o
);
  localparam int XW = OW + 3;

  logic [XW-1:0] x_bytes, x_round;
  logic [DW-1:0] pitch_al;
  logic [AW-1:0] row_base;

  always_comb begin
    case (depth)
      2'd0:    x_bytes = {3'b000, xoff};
      2'd1:    x_bytes = {2'b00, xoff, 1'b0};
      default: x_bytes = {1'b0, xoff, 2'b00};
    endcase
    x_round  = (x_bytes + XW'(31)) & ~XW'(31);
    pitch_al = {pitch_hi, 5'b00000};
    row_base = AW'(yoff) * AW'(pitch_al);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_addr_o <= '0;
    else        start_addr_o <= row_base + AW'(x_round);
  end

  // R7
  start_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_addr_o[4:0] == 5'd0);
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int DW = 16,
  parameter int OW = 12,
  localparam int AW = OW + DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [4:0]    wr_slot,
  input  logic [DW-1:0] wr_data,
  output logic          hsync,
  output logic          vsync,
  output logic          blank,
  output logic          active,
  output logic [AW-1:0] start_addr
);
  timing_t       tm;
  ctrl_t         ctrl;
  logic [DW-6:0] pitch_hi;
  logic [OW-1:0] xoff, yoff;
  logic [1:0]    depth;
  logic [TW-1:0] hpos, vpos;
  logic          line_end, frame_wrap;

  rtg_regs #(.DW(DW), .OW(OW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot),
    .wr_data(wr_data), .frame_wrap(frame_wrap), .tm_o(tm), .ctrl_o(ctrl),
    .pitch_hi_o(pitch_hi), .xoff_o(xoff), .yoff_o(yoff), .depth_o(depth)
  );

  rtg_counters u_cnt (
    .clk(clk), .rst_n(rst_n), .h_total(tm.h_total), .v_total(tm.v_total),
    .hpos_o(hpos), .vpos_o(vpos), .line_end_o(line_end),
    .frame_wrap_o(frame_wrap)
  );

  rtg_window u_win (
    .clk(clk), .rst_n(rst_n), .tm(tm), .ctrl(ctrl), .hpos(hpos), .vpos(vpos),
    .hsync_o(hsync), .vsync_o(vsync), .blank_o(blank), .active_o(active)
  );

  rtg_addr #(.DW(DW), .OW(OW), .AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .pitch_hi(pitch_hi), .xoff(xoff), .yoff(yoff),
    .depth(depth), .start_addr_o(start_addr)
  );

  // R3
  frame_wrap_at_line_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |-> line_end);
endmodule

// File: tb/test_raster_timing_gen.sv
module test_raster_timing_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_slot = '0;
  logic [15:0] wr_data = '0;
  logic        hsync, vsync, blank, active;
  logic [27:0] start_addr;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  raster_timing_gen i_raster_timing_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot),
    .wr_data(wr_data), .hsync(hsync), .vsync(vsync), .blank(blank),
    .active(active), .start_addr(start_addr)
  );

  task automatic check(input string tag, input longint got, input longint exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic logic sig(input int sel);
    case (sel)
      0:       return hsync;
      1:       return vsync;
      2:       return active;
      default: return blank;
    endcase
  endfunction

  task automatic wait_level(input int sel, input logic lvl, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (sig(sel) !== lvl);
  endtask

  task automatic period(input int sel, output int width, output int per);
    int n, lo;
    wait_level(sel, 1'b0, n);
    wait_level(sel, 1'b1, n);
    wait_level(sel, 1'b0, width);
    wait_level(sel, 1'b1, lo);
    per = width + lo;
  endtask

  task automatic wr(input int slot, input int data);
    @(negedge clk);
    wr_en = 1'b1;
    wr_slot = 5'(slot);
    wr_data = 16'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic window(input int len, output int hs, output int vs,
                        output int act, output int blo);
    hs = 0; vs = 0; act = 0; blo = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      hs  += int'(hsync);
      vs  += int'(vsync);
      act += int'(active);
      blo += int'(!blank);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 hsync", hsync, 0);
    check("R1 vsync", vsync, 0);
    check("R1 blank", blank, 1);
    check("R1 active", active, 0);
    check("R1 start_addr", start_addr, 0);
  endtask

  task automatic t_mode_a();
    int w, p, hs, vs, act, blo;
    wr(8, 8); wr(9, 8); wr(10, 3); wr(11, 1); wr(12, 9);
    wr(6, 14); wr(1, 10); wr(2, 2); wr(4, 0); wr(5, 12);
    wr(20, 'h033);
    repeat (300) @(negedge clk);
    period(0, w, p);
    check("R2 line period", p, 10);
    check("R2 hsync width", w, 2);
    period(1, w, p);
    check("R3 frame period", p, 70);
    check("R3 vsync width", w, 10);
    window(140, hs, vs, act, blo);
    check("R2 hsync count", hs, 28);
    check("R3 vsync count", vs, 20);
    check("R4 active count", act, 40);
    check("R4 unblanked count", blo, 40);
  endtask

  task automatic t_ctrl_modes();
    int hs, vs, act, blo;
    wr(20, 'h433); repeat (4) @(negedge clk);
    window(140, hs, vs, act, blo);
    check("R5 forced blank unblanked", blo, 0);
    check("R5 active unaffected", act, 40);
    wr(20, 'h030); repeat (4) @(negedge clk);
    window(140, hs, vs, act, blo);
    check("R6 vsync suspend vs", vs, 0);
    check("R6 vsync suspend hs", hs, 28);
    wr(20, 'h003); repeat (4) @(negedge clk);
    window(140, hs, vs, act, blo);
    check("R6 hsync suspend hs", hs, 0);
    check("R6 hsync suspend vs", vs, 20);
    wr(20, 'h010); repeat (4) @(negedge clk);
    window(140, hs, vs, act, blo);
    check("R6 single enable bit hs", hs, 28);
    wr(20, 'h400); repeat (4) @(negedge clk);
    window(140, hs, vs, act, blo);
    check("R6 power down hs", hs, 0);
    check("R6 power down vs", vs, 0);
    check("R5 power down unblanked", blo, 0);
    wr(20, 'h033); repeat (4) @(negedge clk);
  endtask

  task automatic t_start_addr();
    wr(16, 640); wr(19, 1); wr(17, 32); wr(18, 3);
    @(negedge clk);
    check("R7 depth1 address", start_addr, 1984);
    wr(19, 0); wr(17, 5);
    @(negedge clk);
    check("R7 depth0 rounding", start_addr, 1952);
    wr(19, 2); wr(17, 9);
    @(negedge clk);
    check("R7 depth2 rounding", start_addr, 1984);
    wr(16, 650);
    @(negedge clk);
    check("R7 pitch low bits ignored", start_addr, 1984);
  endtask

  task automatic t_pan();
    int hs, vs, act, blo;
    fork
      window(140, hs, vs, act, blo);
      begin
        repeat (30) @(negedge clk);
        wr(17, 64);
      end
    join
    check("R8 pan hs", hs, 28);
    check("R8 pan vs", vs, 20);
    check("R8 pan active", act, 40);
    check("R8 pan unblanked", blo, 40);
    check("R8 pan address", start_addr, 2176);
  endtask

  task automatic t_shadow();
    int n, w, p, hs, vs, act, blo;
    wait_level(1, 1'b1, n);
    wait_level(1, 1'b0, n);
    wr(8, 10); wr(12, 11);
    period(0, w, p);
    check("R9 old line period kept", p, 10);
    wait_level(1, 1'b1, n);
    wait_level(1, 1'b0, n);
    period(0, w, p);
    check("R9 new line period", p, 12);
    check("R9 new hsync width", w, 2);
    period(1, w, p);
    check("R9 new frame period", p, 84);
    window(84, hs, vs, act, blo);
    check("R9 new vsync count", vs, 12);
    check("R9 new active count", act, 20);
  endtask

  task automatic t_ignored();
    int hs, vs, act, blo;
    logic [27:0] addr_before;
    addr_before = start_addr;
    wr(13, 'hFFFF); wr(7, 5); wr(0, 3); wr(3, 1); wr(14, 2); wr(15, 4);
    wr(25, 'hFFFF);
    repeat (200) @(negedge clk);
    window(168, hs, vs, act, blo);
    check("R10 hsync count", hs, 28);
    check("R10 vsync count", vs, 24);
    check("R10 active count", act, 40);
    check("R10 address kept", start_addr, addr_before);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_mode_a();
    t_ctrl_modes();
    t_start_addr();
    t_pan();
    t_shadow();
    t_ignored();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule